// File: doc/BRIEF.md
# Vector Immediate Merge Unit

This unit computes the result of a masked merge between a vector source register and a 5-bit immediate, one vector register wide. The caller presents the instruction word, the three operand registers (source, old destination and the mask held in register 0) and the vector state: element width, starting element, active length and the element limit. It then raises a start strobe. Each element falls into one of three regions by its index. Body elements take either the sign-extended immediate or the source element, as their mask bit selects. Elements below the start index and elements past the active length or past the element limit keep their old destination value.

The result is registered. One cycle after a legal start, the unit presents the new destination value together with a write enable, a done strobe and a pulse that tells the surrounding core to reset its start-element counter. If the instruction names register 0 as its destination, it is refused. In that case only an illegal-instruction flag appears and the held result does not change.

Top module: `vecImmMerge`

## Requirements
- R1: `srcIdxOut` equals instruction bits [24:20] in the same cycle. When `wrEnOut` is high, `dstIdxOut` equals bits [11:7] of the instruction that was started one cycle earlier.
- R2: The immediate is taken from instruction bits [19:15] and sign-extended to the element width (so 5'b10000 becomes all ones in its top bits, and 5'b01111 becomes 15).
- R3: For a body element, a mask bit of 1 selects the immediate and a mask bit of 0 selects the source element.
- R4: Elements whose index is below `vstartIn` keep their `oldDstIn` value.
- R5: Elements whose index is at or above `vlIn` keep their `oldDstIn` value.
- R6: Elements whose index is at or above `vlmaxIn` keep their `oldDstIn` value, even when `vlIn` is larger.
- R7: A start with destination field (bits [11:7]) equal to 0 raises `illegalOut` one cycle later. In that cycle `wrEnOut`, `doneOut` and `clrVstartOut` stay low and `resultOut` keeps its previous value.
- R8: A legal start raises `wrEnOut`, `doneOut` and `clrVstartOut` for exactly the next cycle. Without a start, none of the strobes is high. Starts may arrive in consecutive cycles.
- R9: When `vlIn` is 0 or `vstartIn` is at least `vlIn`, the result equals `oldDstIn` and `wrEnOut` still asserts.
- R10: `sewIn` encodes the element width as 00=8, 01=16, 10=32 and 11=64 bits. Element i uses mask bit i whatever the width, so mask bits at or above VLEN/SEW have no effect.
- R11: After reset, `resultOut` is zero and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| startIn | input | 1 | Start strobe, one cycle per instruction |
| instrIn | input | 32 | Instruction word |
| srcVecIn | input | VLEN | Source vector register value |
| oldDstIn | input | VLEN | Current destination register value |
| maskIn | input | VLEN/8 | Low bits of mask register 0 |
| sewIn | input | 2 | Element width code |
| vstartIn | input | IW | First element index to process |
| vlIn | input | IW | Active vector length |
| vlmaxIn | input | IW | Element limit for the current grouping |
| srcIdxOut | output | 5 | Decoded source register index |
| dstIdxOut | output | 5 | Registered destination register index |
| resultOut | output | VLEN | New destination value |
| wrEnOut | output | 1 | Destination write enable |
| illegalOut | output | 1 | Illegal-instruction flag |
| clrVstartOut | output | 1 | Pulse to reset the start-element counter |
| doneOut | output | 1 | Completion strobe |

## Verification
Two things can fall in the same cycle. The first is the retirement of one instruction, with its write enable, done and clear pulses. The second is the acceptance of the next start, whose operands are already on the inputs. The bench provokes this by holding start high over consecutive cycles, with a legal, an illegal and another legal instruction in sequence. The scoreboard then checks three things: each retirement reflects only its own operands, the refused instruction leaves the held result untouched between its two legal neighbours, and the strobes never merge across the boundary.

// File: rtl/vecImmMergePkg.sv
package vecImmMergePkg;

  // Strobes passed from control to datapath on an accepted start
  typedef struct packed {
    logic load;   // legal start: capture merged result
    logic trap;   // refused start: hold result
  } mergeStrobe_t;

  localparam int SEW_CODES = 4;
  localparam int MIN_SEW   = 8;

endpackage

// File: rtl/vecImmMergeCtrl.sv
module vecImmMergeCtrl
  import vecImmMergePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic [4:0]   dstIdx,
  output mergeStrobe_t strobe,
  output logic [4:0]   dstIdxOut,
  output logic         wrEnOut,
  output logic         illegalOut,
  output logic         clrVstartOut,
  output logic         doneOut
);

  logic dstIsMask;
  assign dstIsMask   = (dstIdx == 5'd0);
  assign strobe.load = startIn && !dstIsMask;
  assign strobe.trap = startIn && dstIsMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstIdxOut    <= '0;
      wrEnOut      <= 1'b0;
      illegalOut   <= 1'b0;
      clrVstartOut <= 1'b0;
      doneOut      <= 1'b0;
    end else begin
      wrEnOut      <= strobe.load;
      doneOut      <= strobe.load;
      clrVstartOut <= strobe.load;
      illegalOut   <= strobe.trap;
      if (strobe.load) dstIdxOut <= dstIdx;
    end
  end

endmodule

// File: rtl/vecImmMergeDp.sv
module vecImmMergeDp
  import vecImmMergePkg::*;
#(
  parameter int VLEN = 128,
  parameter int IW   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mergeStrobe_t           strobe,
  input  logic [4:0]             immIn,
  input  logic [VLEN-1:0]        srcVecIn,
  input  logic [VLEN-1:0]        oldDstIn,
  input  logic [VLEN/MIN_SEW-1:0] maskIn,
  input  logic [1:0]             sewIn,
  input  logic [IW-1:0]          vstartIn,
  input  logic [IW-1:0]          vlIn,
  input  logic [IW-1:0]          vlmaxIn,
  output logic [VLEN-1:0]        resultOut
);

  logic [VLEN-1:0] candidate [SEW_CODES];

  // One merged candidate per element width
  for (genvar s = 0; s < SEW_CODES; s++) begin : gSew
    localparam int W = MIN_SEW << s;
    localparam int N = VLEN / W;
    logic [W-1:0] immExt;
    assign immExt = {{(W-5){immIn[4]}}, immIn};

    for (genvar e = 0; e < N; e++) begin : gElem
      localparam logic [IW-1:0] IDX = IW'(e);
      logic inBody;
      assign inBody = (IDX >= vstartIn) && (IDX < vlIn) && (IDX < vlmaxIn);
      assign candidate[s][e*W +: W] = !inBody   ? oldDstIn[e*W +: W] :
                                      maskIn[e] ? immExt             :
                                                  srcVecIn[e*W +: W];
    end
  end

  logic [VLEN-1:0] picked;
  assign picked = candidate[sewIn];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            resultOut <= '0;
    else if (strobe.load) resultOut <= picked;
  end

endmodule

// File: rtl/vecImmMerge.sv
module vecImmMerge
  import vecImmMergePkg::*;
#(
  parameter int VLEN = 128,
  localparam int IW  = $clog2(VLEN) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startIn,
  input  logic [31:0]             instrIn,
  input  logic [VLEN-1:0]         srcVecIn,
  input  logic [VLEN-1:0]         oldDstIn,
  input  logic [VLEN/MIN_SEW-1:0] maskIn,
  input  logic [1:0]              sewIn,
  input  logic [IW-1:0]           vstartIn,
  input  logic [IW-1:0]           vlIn,
  input  logic [IW-1:0]           vlmaxIn,
  output logic [4:0]              srcIdxOut,
  output logic [4:0]              dstIdxOut,
  output logic [VLEN-1:0]         resultOut,
  output logic                    wrEnOut,
  output logic                    illegalOut,
  output logic                    clrVstartOut,
  output logic                    doneOut
);

  mergeStrobe_t strobe;
  logic unusedInstrBits;
  assign unusedInstrBits = ^{instrIn[31:25], instrIn[14:12], instrIn[6:0]};
  assign srcIdxOut = instrIn[24:20];

  vecImmMergeCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .dstIdx(instrIn[11:7]),
    .strobe(strobe), .dstIdxOut(dstIdxOut), .wrEnOut(wrEnOut),
    .illegalOut(illegalOut), .clrVstartOut(clrVstartOut), .doneOut(doneOut)
  );

  vecImmMergeDp #(.VLEN(VLEN), .IW(IW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .immIn(instrIn[19:15]),
    .srcVecIn(srcVecIn), .oldDstIn(oldDstIn), .maskIn(maskIn), .sewIn(sewIn),
    .vstartIn(vstartIn), .vlIn(vlIn), .vlmaxIn(vlmaxIn), .resultOut(resultOut)
  );

endmodule

// File: rtl/vecImmMergeChk.sv
module vecImmMergeChk #(
  parameter int VLEN = 128,
  parameter int IW   = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            startIn,
  input logic [31:0]     instrIn,
  input logic [VLEN-1:0] oldDstIn,
  input logic [IW-1:0]   vstartIn,
  input logic [IW-1:0]   vlIn,
  input logic [4:0]      dstIdxOut,
  input logic [VLEN-1:0] resultOut,
  input logic            wrEnOut,
  input logic            illegalOut,
  input logic            clrVstartOut,
  input logic            doneOut
);

  assert_legal_retire_R8: assert property (@(posedge clk) disable iff (!rstN)
    startIn && instrIn[11:7] != 5'd0 |=> wrEnOut && doneOut && clrVstartOut && !illegalOut);

  assert_refuse_dst0_R7: assert property (@(posedge clk) disable iff (!rstN)
    startIn && instrIn[11:7] == 5'd0 |=> illegalOut && !wrEnOut && !doneOut && !clrVstartOut);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> !wrEnOut && !doneOut && !illegalOut && !clrVstartOut);

  assert_refuse_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> $stable(resultOut));

  assert_empty_body_R9: assert property (@(posedge clk) disable iff (!rstN)
    startIn && instrIn[11:7] != 5'd0 && (vlIn == '0 || vstartIn >= vlIn)
    |=> resultOut == $past(oldDstIn));

  assert_dst_echo_R1: assert property (@(posedge clk) disable iff (!rstN)
    startIn && instrIn[11:7] != 5'd0 |=> dstIdxOut == $past(instrIn[11:7]));

endmodule

bind vecImmMerge vecImmMergeChk #(.VLEN(VLEN), .IW(IW)) i_chk (.*);

// File: tb/test_vecImmMerge.sv
module test_vecImmMerge;
  localparam int VLEN = 128;
  localparam int IW   = $clog2(VLEN) + 1;
  localparam int MW   = VLEN / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [31:0] instrIn = '0;
  logic [VLEN-1:0] srcVecIn = '0, oldDstIn = '0;
  logic [MW-1:0] maskIn = '0;
  logic [1:0] sewIn = '0;
  logic [IW-1:0] vstartIn = '0, vlIn = '0, vlmaxIn = '0;
  logic [4:0] srcIdxOut, dstIdxOut;
  logic [VLEN-1:0] resultOut;
  logic wrEnOut, illegalOut, clrVstartOut, doneOut;

  always #5 clk = ~clk;

  vecImmMerge #(.VLEN(VLEN)) i_vecImmMerge (.*);

  typedef struct {
    logic            ill;
    logic [VLEN-1:0] res;
    logic [4:0]      dst;
    string           tag;
  } exp_t;

  exp_t expQ[$];
  int tests = 0, fails = 0;
  logic [VLEN-1:0] lastRes = '0;
  logic armed = 1'b0;
  bit running = 1'b0;

  task automatic check(bit ok, string tag, string what, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(logic [4:0] vs2, logic [4:0] imm, logic [4:0] vd);
    return {6'b010111, 1'b0, vs2, imm, 3'b011, vd, 7'b1010111};
  endfunction

  function automatic logic [VLEN-1:0] model(logic [4:0] imm, logic [VLEN-1:0] src, logic [VLEN-1:0] old,
      logic [MW-1:0] mask, logic [1:0] sew, int vs, int vl, int vlmax);
    logic [VLEN-1:0] r;
    logic [63:0] immx;
    int w;
    w = 8 << sew;
    immx = {{59{imm[4]}}, imm};
    r = old;
    for (int i = 0; i < VLEN / w; i++) begin
      if (i >= vs && i < vl && i < vlmax) begin
        for (int b = 0; b < w; b++)
          r[i*w+b] = mask[i] ? immx[b] : src[i*w+b];
      end
    end
    return r;
  endfunction

  task automatic issue(string tag, logic [4:0] vs2, logic [4:0] imm, logic [4:0] vd, logic [1:0] sew,
      int vs, int vl, int vlmax, logic [MW-1:0] mask);
    exp_t e;
    logic [VLEN-1:0] src, old;
    src = {$urandom, $urandom, $urandom, $urandom};
    old = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    startIn = 1'b1; instrIn = mkInstr(vs2, imm, vd); srcVecIn = src; oldDstIn = old;
    maskIn = mask; sewIn = sew; vstartIn = IW'(vs); vlIn = IW'(vl); vlmaxIn = IW'(vlmax);
    e.tag = tag; e.dst = vd; e.ill = (vd == 5'd0);
    if (!e.ill) lastRes = model(imm, src, old, mask, sew, vs, vl, vlmax);
    e.res = lastRes;
    expQ.push_back(e);
    #1 check(srcIdxOut == vs2, "R1", "srcIdx", VLEN'(srcIdxOut), VLEN'(vs2));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      startIn = 1'b0;
    end
  endtask

  always @(posedge clk) armed <= startIn;

  // Monitor: results appear one cycle after each start
  always @(negedge clk) begin
    if (running) begin
      if (armed) begin
        exp_t e;
        e = expQ.pop_front();
        check(illegalOut == e.ill, e.tag, "illegal", VLEN'(illegalOut), VLEN'(e.ill));
        check(wrEnOut == !e.ill && doneOut == !e.ill && clrVstartOut == !e.ill, e.tag, "wr/done/clr",
              VLEN'({wrEnOut, doneOut, clrVstartOut}), e.ill ? '0 : VLEN'(3'b111));
        check(resultOut == e.res, e.tag, "result", resultOut, e.res);
        if (!e.ill) check(dstIdxOut == e.dst, e.tag, "dstIdx R1", VLEN'(dstIdxOut), VLEN'(e.dst));
      end else begin
        check(!wrEnOut && !doneOut && !illegalOut && !clrVstartOut, "R8", "idle strobes",
              VLEN'({wrEnOut, doneOut, illegalOut, clrVstartOut}), '0);
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(resultOut == '0 && !wrEnOut && !doneOut && !illegalOut && !clrVstartOut, "R11", "reset state",
          resultOut, '0);
    running = 1'b1;
    issue("R3 R2 sew8", 5'd3, 5'b11101, 5'd4, 2'b00, 0, 16, 16, 16'hA5C3); idle(1);
    issue("R2 sew16 imm15", 5'd7, 5'b01111, 5'd8, 2'b01, 0, 8, 8, 16'h00F0); idle(1);
    issue("R2 R10 sew32 imm-16", 5'd9, 5'b10000, 5'd12, 2'b10, 0, 4, 4, 16'h0005); idle(1);
    issue("R10 sew64", 5'd1, 5'b00101, 5'd2, 2'b11, 0, 2, 2, 16'h0002); idle(1);
    issue("R4 prestart", 5'd5, 5'b11111, 5'd6, 2'b00, 5, 16, 16, 16'hFFFF); idle(1);
    issue("R5 tail vl", 5'd5, 5'b00001, 5'd6, 2'b00, 0, 10, 16, 16'h3333); idle(1);
    issue("R6 vlmax limit", 5'd5, 5'b10101, 5'd6, 2'b00, 0, 16, 4, 16'hFFFF); idle(1);
    issue("R9 vl zero", 5'd5, 5'b01010, 5'd6, 2'b00, 0, 0, 16, 16'hFFFF); idle(1);
    issue("R9 vstart>=vl", 5'd5, 5'b01010, 5'd6, 2'b01, 8, 8, 8, 16'hFFFF); idle(1);
    issue("R7 dst zero", 5'd5, 5'b01010, 5'd0, 2'b00, 0, 16, 16, 16'hFFFF); idle(1);
    issue("R10 high mask ignored", 5'd11, 5'b11000, 5'd13, 2'b01, 0, 8, 8, 16'hFF00); idle(1);
    // Back-to-back: retire and accept in the same cycle
    issue("R8 b2b first", 5'd14, 5'b00011, 5'd15, 2'b00, 2, 14, 16, 16'h5A5A);
    issue("R7 b2b refused", 5'd14, 5'b11100, 5'd0, 2'b10, 0, 4, 4, 16'h000F);
    issue("R8 b2b third", 5'd16, 5'b10011, 5'd17, 2'b11, 1, 2, 2, 16'h0003);
    idle(3);
    running = 1'b0;
    check(expQ.size() == 0, "R8", "queue drained", VLEN'(expQ.size()), '0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule